// File: doc/BRIEF.md
# Lazy Field Adder/Subtracter

This block adds or subtracts two prime-field elements for a Montgomery-based elliptic-curve datapath and deliberately skips the final modular reduction. A sum comes out as the plain integer A + B. A difference comes out as A − B + 4M, which keeps it positive without any comparison against the modulus. The Montgomery multiplication that consumes the value folds it back into the field, so a result anywhere in (0, 8M) is acceptable.

The operands are wide, but the datapath is narrow. A three-input slice adder walks the padded operands one slice at a time, least significant slice first. A two-bit carry register links each slice to the next. The caller presents the operands, the 4M constant and the operation select together with a one-cycle start strobe. It then waits for the done pulse, after which the result stays unchanged until the next accepted start.

Top module: `lazy_field_addsub`

## Requirements
- R1: With `sub` low, `result` equals (op_a + op_b) mod 2^(W+3). No modular correction is applied.
- R2: With `sub` high, `result` equals (op_a − op_b + four_m) mod 2^(W+3). It is formed as op_a + four_m + (bitwise inverse of op_b) + 1.
- R3: When both operands are below four_m (= 4M), a difference lies in (0, 8M). A sum lies in [0, 8M) and is zero only when both operands are zero.
- R4: `done` is a single-cycle pulse. It goes high exactly NSL rising edges after the edge that accepts `start`, where NSL = ceil((W+3)/SLW). This is 5 slice cycles for the default W=256 and SLW=54, so the operation spans 7 cycles from the start cycle to the done cycle, both counted.
- R5: A `start` that arrives while an operation is in flight is ignored. It does not change that operation's result or its done timing.
- R6: After `done`, `result` holds its value until the next accepted `start`, whatever the inputs do.
- R7: Synchronous active-high `rst` clears `result` to zero and holds `done` low.
- R8: Slices are processed least significant first, and every carry or borrow crosses each slice boundary. The full-width result is therefore exact for carry chains that span several slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe; accepted only when idle |
| sub | input | 1 | 0 = add, 1 = subtract (with 4M offset) |
| op_a | input | W+3 | First operand |
| op_b | input | W+3 | Second operand |
| four_m | input | W+3 | Precomputed 4·M |
| result | output | W+3 | Unreduced sum or offset difference |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses an 8-bit modulus with 3-bit slices, so each operand spans four slices and carries cross slice boundaries on almost every operation. It sweeps a grid of operands that includes 0 and 4M−1 for several moduli, in both operations. A lost or misplaced inter-slice carry corrupts the upper bits of the result. A missing "+1" of the inversion or a dropped 4M offset is off by one or by 4M and leaves the (0, 8M) range. The bench also places a start strobe during a busy operation and changes the inputs after done. A design that restarted or kept updating the result would return the wrong value or move done.

// File: rtl/lazy_field_addsub.sv
module lazy_field_addsub #(
  parameter int W   = 256,
  parameter int SLW = 54
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           sub,
  input  logic [W+2:0]   op_a,
  input  logic [W+2:0]   op_b,
  input  logic [W+2:0]   four_m,
  output logic [W+2:0]   result,
  output logic           done
);
  localparam int RW  = W + 3;
  localparam int NSL = (RW + SLW - 1) / SLW;
  localparam int PW  = NSL * SLW;
  localparam int CW  = $clog2(NSL + 1);

  logic [PW-1:0]  a_q, b_q, k_q, res_q;
  logic [1:0]     cy_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, done_q;
  logic [SLW+1:0] sum;

  assign sum = {2'b00, a_q[SLW-1:0]} + {2'b00, b_q[SLW-1:0]}
             + {2'b00, k_q[SLW-1:0]} + {{SLW{1'b0}}, cy_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; k_q <= '0; res_q <= '0;
      cy_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        a_q    <= PW'(op_a);
        b_q    <= sub ? PW'(~op_b) : PW'(op_b);
        k_q    <= sub ? PW'(four_m) : '0;
        cy_q   <= {1'b0, sub};
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        res_q <= {sum[SLW-1:0], res_q[PW-1:SLW]};
        a_q   <= a_q >> SLW;
        b_q   <= b_q >> SLW;
        k_q   <= k_q >> SLW;
        cy_q  <= sum[SLW+1:SLW];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NSL - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign result = res_q[RW-1:0];
  assign done   = done_q;

  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r4_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy_q) && !busy_q));
  a_r5_busy_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != CW'(NSL - 1)) |=> busy_q);
  a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start) |=> $stable(result));
  a_r8_carry_bound: assert property (@(posedge clk) disable iff (rst)
    cy_q != 2'b11);
endmodule

// File: tb/tb_lazy_field_addsub.sv
module tb_lazy_field_addsub;
  localparam int W   = 8;
  localparam int SLW = 3;
  localparam int RW  = W + 3;
  localparam int NSL = (RW + SLW - 1) / SLW;
  localparam int MASK = (1 << RW) - 1;

  logic clk = 0, rst = 1, start = 0, sub = 0;
  logic [RW-1:0] op_a = '0, op_b = '0, four_m = '0;
  logic [RW-1:0] result;
  logic done;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lazy_field_addsub #(.W(W), .SLW(SLW)) dut (
    .clk(clk), .rst(rst), .start(start), .sub(sub), .op_a(op_a),
    .op_b(op_b), .four_m(four_m), .result(result), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic run_op(input int av, input int bv, input int m4, input bit s,
                        input bit poke_busy);
    int exp;
    bit lat_ok;
    @(negedge clk);
    op_a = RW'(av); op_b = RW'(bv); four_m = RW'(m4); sub = s; start = 1;
    @(negedge clk);
    start = 0;
    if (poke_busy) begin
      start = 1; op_a = RW'(bv); op_b = RW'(av); sub = !s;
    end
    lat_ok = 1;
    for (int k = 1; k <= NSL; k++) begin
      if (k > 1) start = 0;
      if (done !== 1'b0) lat_ok = 0;
      @(negedge clk);
    end
    start = 0;
    if (done !== 1'b1) lat_ok = 0;
    chk(lat_ok, poke_busy ? "R4/R5 latency" : "R4 latency", int'(done), 1);
    exp = s ? ((av - bv + m4) & MASK) : ((av + bv) & MASK);
    chk(int'(result) == exp, poke_busy ? "R5 ignored start" : (s ? "R2/R8 sub" : "R1/R8 add"),
        int'(result), exp);
    if (av < m4 && bv < m4) begin
      if (s || av != 0 || bv != 0)
        chk(int'(result) > 0 && int'(result) < 2 * m4, "R3 range", int'(result), 2 * m4);
    end
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse", int'(done), 0);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    int ms[3] = '{255, 171, 3};
    int keep;
    repeat (3) @(negedge clk);
    chk(result == '0, "R7 reset result", int'(result), 0);
    chk(done == 1'b0, "R7 reset done", int'(done), 0);
    rst = 0;
    // carry chain across every slice boundary (R8)
    run_op(MASK, 1, 0, 0, 0);
    run_op(0, 1, 4, 1, 0);
    run_op(12'h3F8, 12'h008, 1020, 0, 0);
    foreach (ms[mi]) begin
      int m4 = 4 * ms[mi];
      for (int i = 0; i < 32; i++)
        for (int j = 0; j < 32; j++)
          for (int s = 0; s < 2; s++)
            run_op((i * (m4 - 1)) / 31, (j * (m4 - 1)) / 31, m4, s[0], 0);
    end
    // R5: start during busy is ignored
    run_op(700, 300, 1020, 1, 1);
    run_op(5, 900, 1020, 0, 1);
    // R6: result holds after done
    keep = int'(result);
    op_a = 11'd77; op_b = 11'd99; sub = 1;
    repeat (12) @(negedge clk);
    chk(int'(result) == keep, "R6 hold", int'(result), keep);
    chk(done == 1'b0, "R6 no done", int'(done), 0);
    summary();
  end
endmodule